// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital sequencer for a 12-bit successive-approximation converter. For each conversion it spends one cycle tracking the selected input. It then tests the capacitor-DAC code one bit at a time, starting at the most significant bit. A bit is kept when the single-bit comparator reports that the DAC level does not exceed the input. The analog multiplexer, track-and-hold, comparator and reference sit outside the block, and only their control and status signals appear as ports. The result is straight binary, with one LSB equal to full scale divided by 4096.

A conversion starts from one of three triggers: a software start pulse, the rising edge of an external convert pin, or a tick from a periodic timer. The pin and the timer each have their own enable. In single mode the block returns to idle after each result. In continuous mode it starts the next track cycle straight after the finishing cycle, and it keeps doing so until the continuous enable is cleared. Nine channels can be selected: inputs 0 to 7 are external, and channel 8 is the internal temperature-proportional voltage.

The raw code is corrected with an offset and a gain held in calibration registers. These registers come out of reset with neutral values, and software may overwrite them. The corrected code is packed into a 16-bit word, with the channel tag in the upper nibble. Each update of the word raises a one-cycle done pulse and a sticky interrupt flag.

The state machine has four states. S_IDLE waits for a trigger. S_TRACK holds the track output for one cycle. S_TRIAL runs the 12 bit trials. S_FINISH corrects the code and writes the result. The transitions are:
- S_IDLE to S_TRACK on an accepted trigger.
- S_TRACK to S_TRIAL unconditionally.
- S_TRIAL to itself while trial bits remain.
- S_TRIAL to S_FINISH after bit 0 has been tried.
- S_FINISH to S_TRACK when continuous mode is enabled.
- S_FINISH to S_IDLE otherwise.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset res_hi, res_lo, dac_code, done, irq_flag, busy and track are all 0, the offset register is 0 and the gain register is 2048.
- R2: A conversion is started by a sw_start high at a clock edge, by a 0-to-1 change of ext_conv while ext_en is 1, or by tmr_tick high while tmr_en is 1. A tick with tmr_en at 0, or a pin edge with ext_en at 0, starts nothing. A pin held high does not start a second conversion.
- R3: In the cycle after the trigger edge, track and busy are 1. The 12 following cycles are bit trials, MSB first. The first trial drives dac_code 0x800. Each trial bit is kept only if cmp_in is 1 (DAC level at or below the input). The result and done appear 14 clock edges after the trigger edge.
- R4: A trigger that arrives while busy is 1 is ignored. This includes a trigger in the finishing cycle, so busy is 0 after the result in single mode.
- R5: The result word is {tag[3:0], code[11:0]}. res_hi[7:4] is the channel tag, res_hi[3:0] is code bits 11:8, and res_lo is code bits 7:0.
- R6: chan_sel is latched at the trigger edge and shown on mux_sel for the whole conversion. Values 0 to 7 are external inputs, and 8 is the temperature channel. Values 9 to 15 act as 8, both on mux_sel and in the tag. Later changes of chan_sel have no effect on the running conversion.
- R7: The code is clamp(floor((raw - offset) * gain / 2048), 0, 4095), where raw is the successive-approximation result. With the reset values of the registers, the code equals raw.
- R8: A cycle with off_wr at 1 loads cal_data into the offset register. A cycle with gain_wr at 1 loads cal_data into the gain register. The values are kept until the next write.
- R9: done is a one-cycle pulse in the cycle the result changes, and irq_flag is set in that same cycle. flag_clr at 1 clears irq_flag. When the set and the clear fall on the same edge, the set wins.
- R10: With cont_en at 1 in the finishing cycle, track is 1 in the same cycle as done, and the next conversion begins. With cont_en at 0 in that cycle, the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start | input | 1 | Software start command |
| ext_conv | input | 1 | External convert pin, rising edge |
| ext_en | input | 1 | Enables the external pin trigger |
| tmr_tick | input | 1 | Periodic timer tick |
| tmr_en | input | 1 | Enables the timer trigger |
| cont_en | input | 1 | Continuous mode enable |
| chan_sel | input | 4 | Channel request (8 = temperature) |
| cmp_in | input | 1 | Comparator: 1 when DAC level is at or below the input |
| off_wr | input | 1 | Write strobe for the offset register |
| gain_wr | input | 1 | Write strobe for the gain register |
| cal_data | input | 12 | Calibration write data |
| flag_clr | input | 1 | Write 1 to clear irq_flag |
| dac_code | output | 12 | Capacitor-DAC code under trial |
| track | output | 1 | Track/sample phase |
| mux_sel | output | 4 | Selected channel to the analog mux |
| busy | output | 1 | Conversion in progress |
| res_hi | output | 8 | Tag and result bits 11:8 |
| res_lo | output | 8 | Result bits 7:0 |
| done | output | 1 | One-cycle result-update pulse |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Two pairs of events can meet in one cycle. The first is the result update that sets irq_flag and a software clear of the same flag. The second is a fresh trigger and the finishing cycle that ends a conversion. The bench holds flag_clr across the edge that writes the result, and it expects the flag to stay set and then drop on the following edge. It also pulses sw_start in the finishing cycle of a single-mode conversion, and it expects busy to be 0 once the result is out. In continuous mode it checks that done and the next track fall in the same cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int CODE_W    = 12;
    localparam int CHAN_W    = 4;
    localparam int TEMP_CH   = 8;
    localparam int GAIN_FRAC = 11;

    typedef enum logic [1:0] {
        S_IDLE,
        S_TRACK,
        S_TRIAL,
        S_FINISH
    } sar_state_t;
endpackage

// File: rtl/sar_trigger.sv
module sar_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_start,
    input  logic ext_conv,
    input  logic ext_en,
    input  logic tmr_tick,
    input  logic tmr_en,
    output logic trig
);
    logic ext_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_conv;
    end

    assign trig = sw_start
                | (ext_en & ext_conv & ~ext_prev)
                | (tmr_en & tmr_tick);
endmodule

// File: rtl/sar_cal.sv
module sar_cal #(
    parameter int CODE_W    = 12,
    parameter int GAIN_FRAC = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              off_wr,
    input  logic              gain_wr,
    input  logic [CODE_W-1:0] cal_data,
    output logic [CODE_W-1:0] off_q,
    output logic [CODE_W-1:0] gain_q
);
    localparam logic [CODE_W-1:0] GAIN_UNITY = CODE_W'(1) << GAIN_FRAC;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q  <= '0;
            gain_q <= GAIN_UNITY;
        end else begin
            if (off_wr)  off_q  <= cal_data;
            if (gain_wr) gain_q <= cal_data;
        end
    end
endmodule

// File: rtl/sar_correct.sv
module sar_correct #(
    parameter int CODE_W    = 12,
    parameter int GAIN_FRAC = 11
) (
    input  logic [CODE_W-1:0] raw,
    input  logic [CODE_W-1:0] off,
    input  logic [CODE_W-1:0] gain,
    output logic [CODE_W-1:0] code
);
    localparam int PROD_W = 2 * CODE_W;

    logic [CODE_W:0]   diff;
    logic [PROD_W-1:0] prod;
    logic              negative;
    logic              over;

    assign diff     = {1'b0, raw} - {1'b0, off};
    assign negative = diff[CODE_W];
    assign prod     = {{CODE_W{1'b0}}, diff[CODE_W-1:0]} * {{CODE_W{1'b0}}, gain};
    assign over     = |prod[PROD_W-1:CODE_W+GAIN_FRAC];

    always_comb begin
        if (negative)  code = '0;
        else if (over) code = '1;
        else           code = prod[CODE_W+GAIN_FRAC-1:GAIN_FRAC];
    end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
    parameter int CODE_W    = sar_pkg::CODE_W,
    parameter int CHAN_W    = sar_pkg::CHAN_W,
    parameter int TEMP_CH   = sar_pkg::TEMP_CH,
    parameter int GAIN_FRAC = sar_pkg::GAIN_FRAC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_start,
    input  logic              ext_conv,
    input  logic              ext_en,
    input  logic              tmr_tick,
    input  logic              tmr_en,
    input  logic              cont_en,
    input  logic [CHAN_W-1:0] chan_sel,
    input  logic              cmp_in,
    input  logic              off_wr,
    input  logic              gain_wr,
    input  logic [CODE_W-1:0] cal_data,
    input  logic              flag_clr,
    output logic [CODE_W-1:0] dac_code,
    output logic              track,
    output logic [CHAN_W-1:0] mux_sel,
    output logic              busy,
    output logic [7:0]        res_hi,
    output logic [7:0]        res_lo,
    output logic              done,
    output logic              irq_flag
);
    import sar_pkg::*;

    localparam int IDX_W = $clog2(CODE_W);
    localparam int RES_W = CHAN_W + CODE_W;
    localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(CODE_W - 1);
    localparam logic [CHAN_W-1:0] TEMP_SEL = CHAN_W'(TEMP_CH);

    sar_state_t        state, state_n;
    logic              trig;
    logic              start_conv;
    logic [CODE_W-1:0] sar_q;
    logic [IDX_W-1:0]  bit_idx;
    logic [CODE_W-1:0] trial_mask;
    logic [CHAN_W-1:0] chan_q;
    logic [CHAN_W-1:0] chan_req;
    logic [RES_W-1:0]  res_word;
    logic [CODE_W-1:0] off_q, gain_q, corr_code;

    sar_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .ext_conv(ext_conv),
        .ext_en(ext_en), .tmr_tick(tmr_tick), .tmr_en(tmr_en), .trig(trig)
    );

    sar_cal #(.CODE_W(CODE_W), .GAIN_FRAC(GAIN_FRAC)) u_cal (
        .clk(clk), .rst_n(rst_n), .off_wr(off_wr), .gain_wr(gain_wr),
        .cal_data(cal_data), .off_q(off_q), .gain_q(gain_q)
    );

    sar_correct #(.CODE_W(CODE_W), .GAIN_FRAC(GAIN_FRAC)) u_corr (
        .raw(sar_q), .off(off_q), .gain(gain_q), .code(corr_code)
    );

    assign trial_mask = CODE_W'(1) << bit_idx;
    assign chan_req   = (chan_sel > TEMP_SEL) ? TEMP_SEL : chan_sel;
    assign start_conv = ((state == S_IDLE) && trig) ||
                        ((state == S_FINISH) && cont_en);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (trig) state_n = S_TRACK;
            S_TRACK:  state_n = S_TRIAL;
            S_TRIAL:  if (bit_idx == '0) state_n = S_FINISH;
            S_FINISH: state_n = cont_en ? S_TRACK : S_IDLE;
        endcase
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sar_q    <= '0;
            bit_idx  <= '0;
            chan_q   <= '0;
            res_word <= '0;
            done     <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start_conv) begin
                sar_q   <= '0;
                bit_idx <= TOP_IDX;
                if (state == S_IDLE) chan_q <= chan_req;
                else                 chan_q <= chan_req;
            end else if (state == S_TRIAL) begin
                if (cmp_in) sar_q <= sar_q | trial_mask;
                if (bit_idx != '0) bit_idx <= bit_idx - 1'b1;
            end
            if (state == S_FINISH) begin
                res_word <= {chan_q, corr_code};
                done     <= 1'b1;
                irq_flag <= 1'b1;
            end else if (flag_clr) begin
                irq_flag <= 1'b0;
            end
        end
    end

    // Combinational outputs
    always_comb begin
        dac_code = (state == S_TRIAL) ? (sar_q | trial_mask) : sar_q;
        track    = (state == S_TRACK);
        busy     = (state != S_IDLE);
        mux_sel  = chan_q;
        res_hi   = res_word[RES_W-1 -: 8];
        res_lo   = res_word[7:0];
    end
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        track,
    input logic        done,
    input logic        irq_flag,
    input logic [3:0]  mux_sel,
    input logic [7:0]  res_hi,
    input logic [11:0] dac_code
);
    // R9: done lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the flag is set whenever the result updates
    a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> irq_flag);

    // R3: the track phase is one cycle and lies inside busy
    a_r3_track_one: assert property (@(posedge clk) disable iff (!rst_n)
        track |=> !track);
    a_r3_track_busy: assert property (@(posedge clk) disable iff (!rst_n)
        track |-> busy);

    // R6: the channel holds for the whole conversion and stays in range
    a_r6_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !track) |-> $stable(mux_sel));
    a_r6_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (mux_sel <= 4'd8));

    // R5: the result tag is a legal channel
    a_r5_tag_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_hi[7:4] <= 4'd8));

    // R3: the DAC code does not move while idle
    a_r3_dac_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(dac_code));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .track(track), .done(done),
    .irq_flag(irq_flag), .mux_sel(mux_sel), .res_hi(res_hi), .dac_code(dac_code)
);

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_start = 0, ext_conv = 0, ext_en = 0, tmr_tick = 0, tmr_en = 0;
    logic        cont_en = 0, off_wr = 0, gain_wr = 0, flag_clr = 0;
    logic [3:0]  chan_sel = 0;
    logic [11:0] cal_data = 0;
    logic [11:0] dac_code;
    logic        track, busy, done, irq_flag, cmp_in;
    logic [3:0]  mux_sel;
    logic [7:0]  res_hi, res_lo;
    int          v_in = 0;
    int          vectors = 0;
    int          fails = 0;
    int          cur_off = 0;
    int          cur_gain = 2048;
    bit          ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp_in = (int'(dac_code) <= v_in);

    sar_conv_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .ext_conv(ext_conv),
        .ext_en(ext_en), .tmr_tick(tmr_tick), .tmr_en(tmr_en), .cont_en(cont_en),
        .chan_sel(chan_sel), .cmp_in(cmp_in), .off_wr(off_wr), .gain_wr(gain_wr),
        .cal_data(cal_data), .flag_clr(flag_clr), .dac_code(dac_code),
        .track(track), .mux_sel(mux_sel), .busy(busy), .res_hi(res_hi),
        .res_lo(res_lo), .done(done), .irq_flag(irq_flag)
    );

    task automatic chk(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int corr(int v, int off, int g);
        int d = v - off;
        int q;
        if (d < 0) return 0;
        q = (d * g) >>> 11;
        return (q > 4095) ? 4095 : q;
    endfunction

    function automatic int word(int tag, int code);
        return (tag << 12) | code;
    endfunction

    task automatic pulse_sw();
        @(negedge clk) sw_start = 1;
        @(negedge clk) sw_start = 0;
    endtask

    task automatic check_result(string req, int tag, int code);
        chk({req, " done"}, done, 1);
        chk({req, " word"}, {res_hi, res_lo}, word(tag, code));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 res", {res_hi, res_lo}, 0);
        chk("R1 dac", dac_code, 0);
        chk("R1 flags", {done, irq_flag, busy, track}, 0);
    endtask

    task automatic t_sequence();
        v_in = 'h900; chan_sel = 3;
        pulse_sw();
        chk("R3 track", {track, busy}, 3);
        chk("R6 mux", mux_sel, 3);
        chan_sel = 5;
        @(negedge clk);
        chk("R3 msb trial", dac_code, 'h800);
        chk("R3 track off", track, 0);
        @(negedge clk);
        chk("R3 second trial", dac_code, 'hC00);
        repeat (3) @(negedge clk);
        chk("R6 mux held", mux_sel, 3);
        repeat (9) @(negedge clk);
        check_result("R3 R5 R7", 3, 'h900);
        chk("R9 flag", irq_flag, 1);
        @(negedge clk);
        chk("R9 pulse", done, 0);
    endtask

    task automatic conv_sw(string req, int v, int ch, int tag);
        v_in = v; chan_sel = ch[3:0];
        pulse_sw();
        repeat (14) @(negedge clk);
        check_result(req, tag, corr(v, cur_off, cur_gain));
    endtask

    task automatic t_patterns();
        conv_sw("R7 zero", 0, 0, 0);
        conv_sw("R7 full", 4095, 7, 7);
        conv_sw("R5 mixed", 'h5A3, 1, 1);
        conv_sw("R6 temp", 1234, 8, 8);
        conv_sw("R6 clamp", 77, 12, 8);
        chk("R6 clamp mux", mux_sel, 8);
    endtask

    task automatic t_busy_ignore();
        v_in = 2000; chan_sel = 2;
        pulse_sw();
        repeat (5) @(negedge clk);
        sw_start = 1;
        @(negedge clk) sw_start = 0;
        repeat (7) @(negedge clk);
        sw_start = 1;
        @(negedge clk);
        check_result("R4", 2, 2000);
        chk("R4 busy after result", busy, 0);
        sw_start = 0;
        @(negedge clk);
        chk("R4 finish trigger ignored", busy, 0);
    endtask

    task automatic t_ext();
        ext_en = 0;
        @(negedge clk) ext_conv = 1;
        @(negedge clk);
        chk("R2 ext disabled", busy, 0);
        ext_conv = 0; ext_en = 1; v_in = 321; chan_sel = 4;
        @(negedge clk) ext_conv = 1;
        @(negedge clk);
        chk("R2 ext start", track, 1);
        repeat (14) @(negedge clk);
        check_result("R2 ext", 4, 321);
        repeat (2) @(negedge clk);
        chk("R2 ext held no retrigger", busy, 0);
        ext_conv = 0; ext_en = 0;
    endtask

    task automatic t_timer();
        tmr_en = 0;
        @(negedge clk) tmr_tick = 1;
        @(negedge clk) tmr_tick = 0;
        chk("R2 tick disabled", busy, 0);
        tmr_en = 1; v_in = 3333; chan_sel = 6;
        @(negedge clk) tmr_tick = 1;
        @(negedge clk) tmr_tick = 0;
        chk("R2 tick start", track, 1);
        repeat (14) @(negedge clk);
        check_result("R2 timer", 6, 3333);
        tmr_en = 0;
    endtask

    task automatic write_cal(int off, int g);
        @(negedge clk) off_wr = 1; cal_data = off[11:0];
        @(negedge clk) off_wr = 0; gain_wr = 1; cal_data = g[11:0];
        @(negedge clk) gain_wr = 0;
        cur_off = off; cur_gain = g;
    endtask

    task automatic t_cal();
        write_cal(100, 3072);
        conv_sw("R8 R7 scaled", 1000, 0, 0);
        chk("R7 scaled value", {res_hi[3:0], res_lo}, 1350);
        conv_sw("R7 floor zero", 50, 0, 0);
        conv_sw("R7 saturate", 4000, 0, 0);
        chk("R7 saturate value", {res_hi[3:0], res_lo}, 4095);
        write_cal(0, 1024);
        conv_sw("R8 half gain", 4095, 1, 1);
        chk("R7 half value", {res_hi[3:0], res_lo}, 2047);
        write_cal(0, 2048);
    endtask

    task automatic t_flag();
        @(negedge clk) flag_clr = 1;
        @(negedge clk) flag_clr = 0;
        chk("R9 clear", irq_flag, 0);
        v_in = 10; chan_sel = 0;
        pulse_sw();
        repeat (13) @(negedge clk);
        flag_clr = 1;
        @(negedge clk);
        chk("R9 set wins", irq_flag, 1);
        chk("R9 done", done, 1);
        @(negedge clk);
        chk("R9 cleared next", irq_flag, 0);
        flag_clr = 0;
    endtask

    task automatic t_cont();
        cont_en = 1; v_in = 300; chan_sel = 5;
        pulse_sw();
        repeat (14) @(negedge clk);
        check_result("R10 first", 5, 300);
        chk("R10 next track", track, 1);
        v_in = 3000;
        repeat (6) @(negedge clk);
        cont_en = 0;
        repeat (8) @(negedge clk);
        check_result("R10 second", 5, 3000);
        chk("R10 stop", {track, busy}, 0);
    endtask

    initial begin
        t_reset();
        t_sequence();
        t_patterns();
        t_busy_ignore();
        t_ext();
        t_timer();
        t_cal();
        t_flag();
        t_cont();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        end
        $finish;
    end
endmodule